// File: doc/BRIEF.md
# Quad-Input Page Program Receiver

This block is the command front end of a serial flash for one write path: a page program in which the address and the data both arrive four bits per clock. The chip-select is active low. Each low period of `cs_n` is one frame, and every clock edge with `cs_n` low carries one serial beat. The opcode comes first, as eight single-bit beats on `sio[0]`. For the quad program opcode, six nibble beats of address follow on `sio[3:0]`, then data bytes at two nibble beats each. The only other opcode recognised is write enable, which sets the write-enable latch.

Data bytes are collected in a page buffer. The buffer's write pointer starts at the low address byte and wraps inside the page. When `cs_n` rises at a byte boundary, with at least one byte received and the latch set, the block starts one program operation on an internal byte array. The operation walks the page and ANDs each received byte into the stored byte, so bits can only go from 1 to 0. A busy flag stays high for a length set at an input. When the busy flag drops, the write-enable latch clears with it.

Top module: `qpp_rx`

## Requirements
- R1: A program frame that ends while the write-enable latch is clear has no effect: `wip` stays low and the array is unchanged.
- R2: A frame that holds exactly eight beats carrying opcode 0x06 sets `wel` at the edge that sees `cs_n` high. The opcode is sent MSB first on `sio[0]`. A frame that holds 0x06 followed by any further beat leaves `wel` unchanged.
- R3: The program opcode is 0x38, sent MSB first on `sio[0]`. It is followed by six address nibbles, high nibble first, with `sio[3]` as the most significant bit of each nibble.
- R4: Each data byte takes two beats, high nibble first. Programming stores the old byte AND the received byte, so no bit ever changes from 0 to 1.
- R5: Data bytes go to successive offsets from the low address byte. Past offset 255 they wrap to offset 0 of the same 256-byte page.
- R6: When a frame sends more bytes than one page holds, the last byte sent to each offset is the one programmed.
- R7: A frame that ends between the two nibbles of a byte, or before all six address nibbles, is aborted. `wip` stays low, the array is unchanged and `wel` keeps its value.
- R8: A program frame with a complete address and no data byte has no effect.
- R9: A program that is accepted raises `wip` at the edge that sees `cs_n` high. `wip` stays high for max(`busy_len`, 256) cycles. `wip` and `wel` both fall at the same edge.
- R10: Any frame that begins while `wip` is high is ignored completely. It sets no latch and changes no byte.
- R11: Only the low 10 address bits select a byte. Bits 9:8 choose the page, and higher address bits are ignored.
- R12: After reset, `wip` and `wel` are low and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one beat per rising edge while `cs_n` is low |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; its low period marks one frame |
| sio | input | 4 | Serial lines; opcode on bit 0, nibbles on all four |
| busy_len | input | 12 | Requested program busy time in cycles (at least 256 are used) |
| rd_addr | input | 10 | Byte address for the array read port |
| rd_data | output | 8 | Array byte at `rd_addr`, combinational |
| wip | output | 1 | Program operation in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any frame starts. They also assume that `busy_len` does not change while `wip` is high, and that `cs_n` stays high for at least one edge between frames. The stimulus drives all inputs on the falling edge. It changes `busy_len` only when the block is idle, and it leaves idle cycles after each rising edge of `cs_n`. Only one frame is sent during a busy period, and it is sent so that it starts and ends while `wip` is still high, which keeps R10 within the assumed input behaviour.

// File: rtl/qpp_pkg.sv
// Shared constants for the quad-input page program receiver.
// Assumes opcodes are eight beats long and the address is six nibbles.
package qpp_pkg;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_QPROG  = 8'h38;
    localparam int         OPC_BEATS = 8;
    localparam int         ADR_NIBS  = 6;
    localparam int         DATA_BEAT = OPC_BEATS + ADR_NIBS;
endpackage

// File: rtl/qpp_frame_rx.sv
// Frame decoder: shifts in the opcode on sio[0], the address and data
// nibbles on sio[3:0], keeps the write-enable latch, and issues a start
// pulse on a clean frame end. Assumes ARR_AW >= 8 and PAGE_AW < ARR_AW.
module qpp_frame_rx
    import qpp_pkg::*;
#(
    parameter int PAGE_AW = 8,
    parameter int ARR_AW  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic [3:0]                sio,
    input  logic                      wip,
    input  logic                      prog_done,
    output logic                      wel,
    output logic                      start,
    output logic [ARR_AW-PAGE_AW-1:0] page_base,
    output logic                      buf_clr,
    output logic                      buf_we,
    output logic [PAGE_AW-1:0]        buf_idx,
    output logic [7:0]                buf_byte
);
    logic              in_frame, ign, hi_pend, got_byte;
    logic [3:0]        cnt, e_cnt;
    logic [7:0]        op;
    logic [ARR_AW-1:0] adr, adr_nxt;
    logic [PAGE_AW-1:0] ptr;
    logic [3:0]        hold;
    logic              active, starting, e_ign, e_hi, is_prog;
    logic              take_adr, take_dat, ending, wren_hit;

    // Effective frame state: a fresh frame behaves as if counters were zero.
    always_comb begin
        active   = !cs_n;
        starting = active && !in_frame;
        e_cnt    = in_frame ? cnt : 4'd0;
        e_ign    = in_frame ? ign : wip;
        e_hi     = in_frame && hi_pend;
        is_prog  = (op == OP_QPROG);
        take_adr = active && !e_ign && is_prog &&
                   (e_cnt >= 4'(OPC_BEATS)) && (e_cnt < 4'(DATA_BEAT));
        take_dat = active && !e_ign && is_prog && (e_cnt == 4'(DATA_BEAT));
        adr_nxt  = {adr[ARR_AW-5:0], sio};
        ending   = cs_n && in_frame && !ign;
        start    = ending && is_prog && (cnt == 4'(DATA_BEAT)) &&
                   got_byte && !hi_pend && wel;
        wren_hit = ending && (op == OP_WREN) && (cnt == 4'(OPC_BEATS));
        buf_clr  = starting && !wip;
        buf_we   = take_dat && e_hi;
        buf_idx  = ptr;
        buf_byte = {hold, sio};
        page_base = adr[ARR_AW-1:PAGE_AW];
    end

    // Beat-by-beat shifting of opcode, address and data nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            ign      <= 1'b0;
            hi_pend  <= 1'b0;
            got_byte <= 1'b0;
            cnt      <= '0;
            op       <= '0;
            adr      <= '0;
            ptr      <= '0;
            hold     <= '0;
        end else if (active) begin
            in_frame <= 1'b1;
            if (starting) begin
                ign      <= wip;
                hi_pend  <= 1'b0;
                got_byte <= 1'b0;
            end
            if (!e_ign) begin
                if (e_cnt < 4'(OPC_BEATS))
                    op <= {op[6:0], sio[0]};
                if (e_cnt < 4'(DATA_BEAT))
                    cnt <= e_cnt + 4'd1;
                if (take_adr) begin
                    adr <= adr_nxt;
                    if (e_cnt == 4'(DATA_BEAT - 1))
                        ptr <= adr_nxt[PAGE_AW-1:0];
                end
                if (take_dat) begin
                    if (!e_hi) begin
                        hold    <= sio;
                        hi_pend <= 1'b1;
                    end else begin
                        ptr      <= ptr + 1'b1;
                        got_byte <= 1'b1;
                        hi_pend  <= 1'b0;
                    end
                end
            end
        end else if (in_frame) begin
            in_frame <= 1'b0;
            cnt      <= '0;
        end
    end

    // Write-enable latch: set by a clean enable frame, cleared at program end.
    always_ff @(posedge clk) begin
        if (!rst_n)          wel <= 1'b0;
        else if (prog_done)  wel <= 1'b0;
        else if (wren_hit)   wel <= 1'b1;
    end

    // R10: a start never overlaps a running program.
    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !wip);
    // R2: the latch rises only from an idle state.
    p_wel_set_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(wip));
endmodule

// File: rtl/qpp_page_buf.sv
// Page buffer: one byte and one valid flag per page offset. Cleared at
// frame start, written by the decoder, read by the program sweep.
module qpp_page_buf #(
    parameter int PAGE_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [7:0]         wr_byte,
    input  logic               wip,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [7:0]         rd_byte,
    output logic               rd_vld
);
    localparam int PAGE = 1 << PAGE_AW;

    logic [7:0]      bytes [PAGE];
    logic [PAGE-1:0] vld;

    // Byte storage; later writes to an offset replace earlier ones.
    always_ff @(posedge clk) begin
        if (we) bytes[wr_idx] <= wr_byte;
    end

    // Valid flags: cleared per frame, set on each byte write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) vld <= '0;
        else if (we)       vld[wr_idx] <= 1'b1;
    end

    // Read port for the program sweep.
    always_comb begin
        rd_byte = bytes[rd_idx];
        rd_vld  = vld[rd_idx];
    end

    // R10: buffer contents are frozen while a program runs.
    p_buf_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> $stable(vld));
endmodule

// File: rtl/qpp_array.sv
// Byte array model with program sequencer: on start, sweeps one page
// offset per cycle, ANDing buffered bytes into the array, and holds wip
// for max(busy_len, page size) cycles. Assumes busy_len steady while busy.
module qpp_array #(
    parameter int PAGE_AW = 8,
    parameter int ARR_AW  = 10,
    parameter int BUSY_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ARR_AW-PAGE_AW-1:0] base_in,
    input  logic [BUSY_W-1:0]         busy_len,
    output logic [PAGE_AW-1:0]        pb_idx,
    input  logic [7:0]                pb_byte,
    input  logic                      pb_vld,
    input  logic [ARR_AW-1:0]         rd_addr,
    output logic [7:0]                rd_data,
    output logic                      wip,
    output logic                      prog_done
);
    localparam int PAGE  = 1 << PAGE_AW;
    localparam int DEPTH = 1 << ARR_AW;
    localparam int CNT_W = ((BUSY_W > PAGE_AW) ? BUSY_W : PAGE_AW) + 1;

    logic [7:0]                mem [DEPTH];
    logic [CNT_W-1:0]          cyc, eff_len;
    logic [ARR_AW-PAGE_AW-1:0] base;
    logic                      sweep;

    // Busy length and sweep window.
    always_comb begin
        eff_len   = (CNT_W'(busy_len) < CNT_W'(PAGE)) ? CNT_W'(PAGE) : CNT_W'(busy_len);
        sweep     = wip && (cyc < CNT_W'(PAGE));
        pb_idx    = cyc[PAGE_AW-1:0];
        prog_done = wip && (cyc == eff_len - 1'b1);
        rd_data   = mem[rd_addr];
    end

    // Sequencer: busy flag, cycle counter and latched page base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip  <= 1'b0;
            cyc  <= '0;
            base <= '0;
        end else if (start) begin
            wip  <= 1'b1;
            cyc  <= '0;
            base <= base_in;
        end else if (wip) begin
            cyc <= cyc + 1'b1;
            if (prog_done) wip <= 1'b0;
        end
    end

    // Array storage: erased on reset, AND-programmed during the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (sweep && pb_vld) begin
            mem[{base, pb_idx}] <= mem[{base, pb_idx}] & pb_byte;
        end
    end

    // R9: busy never ends before the whole page was swept.
    p_busy_covers_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> ($past(cyc) >= CNT_W'(PAGE - 1)));
endmodule

// File: rtl/qpp_rx.sv
// Top of the quad-input page program receiver: frame decoder, page
// buffer and array sequencer. One beat per clock while cs_n is low.
module qpp_rx #(
    parameter int PAGE_AW = 8,
    parameter int ARR_AW  = 10,
    parameter int BUSY_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [3:0]        sio,
    input  logic [BUSY_W-1:0] busy_len,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              wip,
    output logic              wel
);
    localparam int BASE_W = ARR_AW - PAGE_AW;

    logic              start, prog_done, buf_clr, buf_we, pb_vld;
    logic [BASE_W-1:0] page_base;
    logic [PAGE_AW-1:0] buf_idx, pb_idx;
    logic [7:0]        buf_byte, pb_byte;

    qpp_frame_rx #(.PAGE_AW(PAGE_AW), .ARR_AW(ARR_AW)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sio(sio),
        .wip(wip), .prog_done(prog_done), .wel(wel), .start(start),
        .page_base(page_base), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_byte(buf_byte)
    );

    qpp_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .wr_idx(buf_idx), .wr_byte(buf_byte), .wip(wip),
        .rd_idx(pb_idx), .rd_byte(pb_byte), .rd_vld(pb_vld)
    );

    qpp_array #(.PAGE_AW(PAGE_AW), .ARR_AW(ARR_AW), .BUSY_W(BUSY_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .start(start), .base_in(page_base),
        .busy_len(busy_len), .pb_idx(pb_idx), .pb_byte(pb_byte),
        .pb_vld(pb_vld), .rd_addr(rd_addr), .rd_data(rd_data),
        .wip(wip), .prog_done(prog_done)
    );

    // R1: a program only begins when the latch was set.
    p_prog_needs_wel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));
    // R9: the latch is clear once the busy flag falls.
    p_done_clears_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
endmodule

// File: tb/test_qpp_rx.sv
module test_qpp_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  sio = '0;
    logic [11:0] busy_len = 12'd20;
    logic [9:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        wip, wel;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] ref_mem [1024];
    int  m_left = 0;
    bit  m_wel = 0;
    bit  pend_commit = 0;
    bit  pend_wren = 0;
    int  pend_len = 0;
    bit  cmp_en = 0;
    logic [7:0] data_q [$];

    always #5 clk = ~clk;

    qpp_rx i_qpp_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sio(sio),
        .busy_len(busy_len), .rd_addr(rd_addr), .rd_data(rd_data),
        .wip(wip), .wel(wel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model advances once per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0;
            m_wel  = 0;
        end else begin
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) m_wel = 0;
            end
            if (pend_commit) begin m_left = pend_len; pend_commit = 0; end
            if (pend_wren)   begin m_wel = 1; pend_wren = 0; end
        end
    end

    // compare busy flag (R9) and latch (R2) against the model every cycle
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(wip === (m_left > 0), "R9 wip per-cycle", int'(wip), int'(m_left > 0));
            chk(wel === m_wel, "R2 wel per-cycle", int'(wel), int'(m_wel));
        end
    end

    task automatic beat(input logic [3:0] v);
        @(negedge clk);
        cs_n = 1'b0;
        sio  = v;
    endtask

    // sends a frame: opcode, n_adr address nibbles, n_dat data nibbles from data_q
    task automatic frame(input logic [7:0] op, input int n_adr,
                         input logic [23:0] adr, input int n_dat);
        bit busy0 = (m_left > 0);
        logic [7:0] pg [256];
        bit pv [256];
        for (int i = 7; i >= 0; i--) beat({3'b000, op[i]});
        for (int i = 0; i < n_adr; i++) beat(adr[23-4*i -: 4]);
        for (int i = 0; i < n_dat; i++)
            beat(i[0] ? data_q[i/2][3:0] : data_q[i/2][7:4]);
        @(negedge clk);
        cs_n = 1'b1;
        sio  = '0;
        if (!busy0) begin
            if (op == 8'h06 && n_adr == 0 && n_dat == 0) pend_wren = 1;
            if (op == 8'h38 && n_adr == 6 && n_dat >= 2 && n_dat % 2 == 0 && m_wel) begin
                for (int k = 0; k < 256; k++) pv[k] = 0;
                for (int k = 0; k < n_dat / 2; k++) begin
                    pg[(adr[7:0] + k) % 256] = data_q[k];
                    pv[(adr[7:0] + k) % 256] = 1;
                end
                for (int k = 0; k < 256; k++)
                    if (pv[k]) ref_mem[{adr[9:8], 8'(k)}] &= pg[k];
                pend_len = (busy_len < 256) ? 256 : int'(busy_len);
                pend_commit = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (m_left > 0 || pend_commit) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic mem_chk(input logic [9:0] a, input string tag);
        rd_addr = a;
        #1;
        chk(rd_data === ref_mem[a], tag, int'(rd_data), int'(ref_mem[a]));
    endtask

    task automatic wren();
        frame(8'h06, 0, 24'h0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1;
        // R12: reset state
        chk(wip === 1'b0, "R12 wip after reset", int'(wip), 0);
        chk(wel === 1'b0, "R12 wel after reset", int'(wel), 0);
        mem_chk(10'h000, "R12 erased byte");
        mem_chk(10'h3FF, "R12 erased byte");

        // R2: enable frame with an extra beat is ignored
        frame(8'h06, 1, 24'h0, 0);
        chk(wel === 1'b0, "R2 long enable ignored", int'(wel), 0);

        // R1: program without latch
        data_q = '{8'h12};
        frame(8'h38, 6, 24'h000110, 2);
        repeat (3) @(negedge clk);
        chk(wip === 1'b0, "R1 no busy without wel", int'(wip), 0);
        mem_chk(10'h110, "R1 array unchanged");

        // R2: enable sets the latch
        wren();
        chk(wel === 1'b1, "R2 enable sets wel", int'(wel), 1);

        // R3 R4 R9: three bytes programmed, latch cleared at end
        data_q = '{8'h5A, 8'hC3, 8'h0F};
        frame(8'h38, 6, 24'h000110, 6);
        wait_idle();
        mem_chk(10'h110, "R3 first byte");
        mem_chk(10'h111, "R4 second byte");
        mem_chk(10'h112, "R4 third byte");
        mem_chk(10'h113, "R4 untouched neighbour");
        chk(wel === 1'b0, "R9 wel cleared at end", int'(wel), 0);

        // R4: reprogram clears only bits
        wren();
        data_q = '{8'hF0};
        frame(8'h38, 6, 24'h000110, 2);
        wait_idle();
        mem_chk(10'h110, "R4 and-programming");

        // R5: wrap inside the page
        wren();
        data_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        frame(8'h38, 6, 24'h0002FE, 8);
        wait_idle();
        mem_chk(10'h2FE, "R5 before wrap");
        mem_chk(10'h2FF, "R5 page end");
        mem_chk(10'h200, "R5 wrapped start");
        mem_chk(10'h201, "R5 wrapped next");

        // R6: more than a page, last byte wins
        wren();
        data_q.delete();
        for (int k = 0; k < 258; k++) data_q.push_back(8'((k * 7 + 3) ^ 8'h5C));
        frame(8'h38, 6, 24'h000300, 516);
        wait_idle();
        mem_chk(10'h300, "R6 offset 0 overwritten");
        mem_chk(10'h301, "R6 offset 1 overwritten");
        mem_chk(10'h302, "R6 offset 2 single write");
        mem_chk(10'h3FF, "R6 offset 255");

        // R7: abort mid-byte and mid-address
        wren();
        data_q = '{8'h00, 8'h00};
        frame(8'h38, 6, 24'h000180, 3);
        repeat (3) @(negedge clk);
        chk(wip === 1'b0, "R7 mid-byte abort", int'(wip), 0);
        chk(wel === 1'b1, "R7 wel kept", int'(wel), 1);
        mem_chk(10'h180, "R7 array unchanged");
        frame(8'h38, 4, 24'h000180, 0);
        repeat (3) @(negedge clk);
        chk(wip === 1'b0, "R7 partial address abort", int'(wip), 0);

        // R8: address without data
        frame(8'h38, 6, 24'h000190, 0);
        repeat (3) @(negedge clk);
        chk(wip === 1'b0, "R8 no data no program", int'(wip), 0);
        chk(wel === 1'b1, "R8 wel kept", int'(wel), 1);

        // R9 R10: longer busy, frame during busy ignored
        busy_len = 12'd300;
        data_q = '{8'h0F};
        frame(8'h38, 6, 24'h000040, 2);
        repeat (10) @(negedge clk);
        data_q = '{8'h00};
        frame(8'h38, 6, 24'h000041, 2);
        wait_idle();
        mem_chk(10'h040, "R9 long-busy program");
        mem_chk(10'h041, "R10 busy frame ignored");
        busy_len = 12'd20;

        // R11: high address bits ignored
        wren();
        data_q = '{8'h81};
        frame(8'h38, 6, 24'h123456, 2);
        wait_idle();
        mem_chk(10'h056, "R11 aliased byte");
        mem_chk(10'h256, "R11 other page untouched");

        done = 1;
        cmp_en = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule